// File: doc/BRIEF.md
# Nine-Bit UART Receiver with Masked Address Filter

This block receives asynchronous serial frames on a multi-drop line. Each frame has a low start bit, eight data bits sent least significant bit first, a ninth bit and a high stop bit. The line is sampled on a 16x oversampling tick, and every bit is decided by a majority of three samples taken around the middle of the bit. When a frame completes, a filter decides whether to load the byte and the ninth bit into the output buffer and raise the receive flag.

With the multiprocessor control input set, only frames whose ninth bit is 1 can pass. They pass only when the byte equals the node address in every position where the node mask holds a 1, or when it matches the broadcast pattern. Because the mask decides which positions are compared, several nodes can share one address value and still be addressed one at a time. Software normally drops the multiprocessor input once its own address has arrived, so that the data frames that follow are taken. It raises the input again when the data is done.

The receive flag stays set until `ri_clr` is pulsed. While the flag is set, any frame that completes is dropped.

Top module: `mpa_uart_rx`

## Requirements
- R1: While `rx_en` is 0 no frame is received: the flag, the byte and the ninth bit keep their values whatever the line does.
- R2: With `mp_mode` at 0, every completed frame whose stop bit is decided high loads `rx_byte` and `rx_bit9` and sets `ri_flag`, whatever the ninth bit is.
- R3: With `mp_mode` at 1, a frame whose ninth bit is 0 is dropped.
- R4: With `mp_mode` at 1 and ninth bit 1, the frame is taken when `((byte ^ node_addr) & node_mask) == 0`. A mask bit of 0 makes that position don't-care. For example, address 0xC0 with mask 0xFD takes 0xC0 and 0xC2 but not 0xC1, while mask 0xFE takes 0xC1.
- R5: With `mp_mode` at 1 and ninth bit 1, the frame is also taken when the byte is 1 in every position where `node_mask` is 1. This is the broadcast pattern `node_addr | node_mask` with the mask-0 positions treated as don't-care.
- R6: If `ri_flag` is still set when a frame completes, that frame is dropped and `rx_byte`/`rx_bit9` keep their values.
- R7: A one-cycle pulse on `ri_clr` clears `ri_flag`.
- R8: The flag rises at the decision point of the stop bit, on the 9th of its 16 samples. It is still low after the 5th sample of the stop bit and high before the stop bit ends.
- R9: Each bit takes the majority of its 7th, 8th and 9th samples, so one wrong sample among them does not change the received value.
- R10: A start bit whose majority is high is a false start. No frame follows from it and the outputs are unchanged.
- R11: A frame whose stop bit is decided low is dropped.
- R12: Frame format: one start bit (0), eight data bits sent LSB first, the ninth bit, and one stop bit (1), each 16 ticks long. The line is passed through a two-flop synchronizer.
- R13: After reset `ri_flag`, `rx_byte` and `rx_bit9` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial line, idle high |
| os_tick | input | 1 | 16x oversampling strobe, one clock wide |
| rx_en | input | 1 | Receive enable |
| mp_mode | input | 1 | Multiprocessor filtering on |
| node_addr | input | 8 | Node address |
| node_mask | input | 8 | Address mask, 1 = position compared |
| ri_clr | input | 1 | Clears the receive flag |
| rx_byte | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit of the last accepted frame |
| ri_flag | output | 1 | Receive flag |

## Verification
Some properties are checked on every cycle. The receiver returns to idle when disabled, and the frame-complete strobe lasts one cycle. An idle line never starts a frame. The flag rises only on the cycle after a completed frame, and in multiprocessor mode only with the ninth bit set. A full buffer holds its contents until cleared, and a clear always drops the flag. Other behaviour can only be shown by the bench driving whole frames: which bytes the masked and broadcast compares accept, the majority vote against a flipped sample, rejection of false starts and bad stop bits, and where in the stop bit the flag rises.

// File: rtl/mpa_pkg.sv
package mpa_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_NINTH,
    RX_STOP
  } rx_state_e;

  // two-of-three vote over the mid-bit samples
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // masked compare against the node address
  function automatic logic given_hit(input logic [BYTE_W-1:0] rx_b,
                                     input logic [BYTE_W-1:0] addr,
                                     input logic [BYTE_W-1:0] mask);
    return ((rx_b ^ addr) & mask) == '0;
  endfunction

  // broadcast pattern is addr|mask, positions with mask 0 ignored
  function automatic logic bcast_hit(input logic [BYTE_W-1:0] rx_b,
                                     input logic [BYTE_W-1:0] addr,
                                     input logic [BYTE_W-1:0] mask);
    logic [BYTE_W-1:0] pat;
    pat = addr | mask;
    return ((rx_b ^ pat) & mask) == '0;
  endfunction

endpackage

// File: rtl/mpa_line_sync.sv
module mpa_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_sync
);

  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b1;
        else        q <= line_in;
      end
      assign line_sync = q;
    end else begin : g_chain
      logic [STAGES-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], line_in};
      end
      assign line_sync = sr[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/mpa_frame_rx.sv
module mpa_frame_rx
  import mpa_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_s,
  input  logic              os_tick,
  input  logic              rx_en,
  output logic              frame_done,
  output logic              frame_stop_ok,
  output logic [BYTE_W-1:0] frame_data,
  output logic              frame_b9
);

  localparam int unsigned CW = $clog2(OSR) + 1;
  localparam int unsigned BW = $clog2(BYTE_W);
  localparam logic [CW-1:0] S_MID  = CW'(OSR / 2);
  localparam logic [CW-1:0] S_LO   = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] S_HI   = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] S_END  = CW'(OSR);
  localparam logic [BW-1:0] LASTB  = BW'(BYTE_W - 1);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     nxt_cnt;
  logic [BW-1:0]     bitn;
  logic              v_a, v_b;
  logic              bit_dec;
  logic [BYTE_W-1:0] shreg;
  logic              b9_q;
  logic              done_q, stop_q;

  always_comb begin
    nxt_cnt = cnt + 1'b1;
    bit_dec = vote3(v_a, v_b, rx_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RX_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      v_a    <= 1'b1;
      v_b    <= 1'b1;
      shreg  <= '0;
      b9_q   <= 1'b0;
      done_q <= 1'b0;
      stop_q <= 1'b0;
    end else if (!rx_en) begin
      state  <= RX_IDLE;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (os_tick) begin
        if (state == RX_IDLE) begin
          if (!rx_s) begin
            state <= RX_START;
            cnt   <= CW'(1);
          end
        end else begin
          if (nxt_cnt == S_LO)  v_a <= rx_s;
          if (nxt_cnt == S_MID) v_b <= rx_s;
          if (nxt_cnt == S_END) cnt <= '0;
          else                  cnt <= nxt_cnt;

          if (nxt_cnt == S_HI) begin
            case (state)
              RX_START: if (bit_dec) state <= RX_IDLE;
              RX_DATA:  shreg <= {bit_dec, shreg[BYTE_W-1:1]};
              RX_NINTH: b9_q  <= bit_dec;
              RX_STOP: begin
                done_q <= 1'b1;
                stop_q <= bit_dec;
                state  <= RX_IDLE;
                cnt    <= '0;
              end
              default: state <= RX_IDLE;
            endcase
          end

          if (nxt_cnt == S_END) begin
            case (state)
              RX_START: begin
                state <= RX_DATA;
                bitn  <= '0;
              end
              RX_DATA: begin
                if (bitn == LASTB) state <= RX_NINTH;
                else               bitn  <= bitn + 1'b1;
              end
              RX_NINTH: state <= RX_STOP;
              default:  state <= RX_IDLE;
            endcase
          end
        end
      end
    end
  end

  assign frame_done    = done_q;
  assign frame_stop_ok = stop_q;
  assign frame_data    = shreg;
  assign frame_b9      = b9_q;

  // R1: a disabled receiver is parked in idle
  assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (state == RX_IDLE) && !frame_done);

  // R12: the frame-complete strobe is a single cycle
  assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R10: a high line sampled in idle never starts a frame
  assert_idle_line_stays_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_IDLE) && rx_en && os_tick && rx_s |=> (state == RX_IDLE));

endmodule

// File: rtl/mpa_accept_filter.sv
module mpa_accept_filter
  import mpa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic              frame_stop_ok,
  input  logic [BYTE_W-1:0] frame_data,
  input  logic              frame_b9,
  input  logic              mp_mode,
  input  logic [BYTE_W-1:0] node_addr,
  input  logic [BYTE_W-1:0] node_mask,
  input  logic              ri_clr,
  output logic [BYTE_W-1:0] buf_byte,
  output logic              buf_b9,
  output logic              ri
);

  logic addr_ok;
  logic accept;

  always_comb begin
    addr_ok = given_hit(frame_data, node_addr, node_mask) |
              bcast_hit(frame_data, node_addr, node_mask);
    accept  = frame_done & frame_stop_ok & ~ri &
              (~mp_mode | (frame_b9 & addr_ok));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_byte <= '0;
      buf_b9   <= 1'b0;
      ri       <= 1'b0;
    end else if (accept) begin
      buf_byte <= frame_data;
      buf_b9   <= frame_b9;
      ri       <= 1'b1;
    end else if (ri_clr) begin
      ri <= 1'b0;
    end
  end

  // R2: the flag only rises right after a completed frame
  assert_rise_after_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri) |-> $past(frame_done));

  // R3: in multiprocessor mode a taken frame always carries ninth bit 1
  assert_mp_needs_b9_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri) && $past(mp_mode) |-> buf_b9);

  // R6: a full buffer is held until cleared
  assert_hold_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ri && !ri_clr |=> ri && $stable(buf_byte) && $stable(buf_b9));

  // R7: a clear always drops the flag
  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ri && ri_clr |=> !ri);

endmodule

// File: rtl/mpa_uart_rx.sv
module mpa_uart_rx
  import mpa_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  input  logic              os_tick,
  input  logic              rx_en,
  input  logic              mp_mode,
  input  logic [BYTE_W-1:0] node_addr,
  input  logic [BYTE_W-1:0] node_mask,
  input  logic              ri_clr,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_bit9,
  output logic              ri_flag
);

  logic              rx_s;
  logic              fr_done;
  logic              fr_stop_ok;
  logic [BYTE_W-1:0] fr_data;
  logic              fr_b9;

  mpa_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_in   (rx_in),
    .line_sync (rx_s)
  );

  mpa_frame_rx #(.OSR(OSR)) u_frame (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_s          (rx_s),
    .os_tick       (os_tick),
    .rx_en         (rx_en),
    .frame_done    (fr_done),
    .frame_stop_ok (fr_stop_ok),
    .frame_data    (fr_data),
    .frame_b9      (fr_b9)
  );

  mpa_accept_filter u_filter (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_done    (fr_done),
    .frame_stop_ok (fr_stop_ok),
    .frame_data    (fr_data),
    .frame_b9      (fr_b9),
    .mp_mode       (mp_mode),
    .node_addr     (node_addr),
    .node_mask     (node_mask),
    .ri_clr        (ri_clr),
    .buf_byte      (rx_byte),
    .buf_b9        (rx_bit9),
    .ri            (ri_flag)
  );

  // R13: outputs are clear right after reset is released
  assert_reset_clean_R13: assert property (@(posedge clk)
    $rose(rst_n) |-> !ri_flag && (rx_byte == '0) && !rx_bit9);

endmodule

// File: tb/tb_mpa_uart_rx.sv
module tb_mpa_uart_rx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic       os_tick = 1'b0;
  logic       rx_en = 1'b1;
  logic       mp_mode = 1'b0;
  logic [7:0] node_addr = 8'h00;
  logic [7:0] node_mask = 8'h00;
  logic       ri_clr = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_bit9;
  logic       ri_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // bench model of the output buffer
  bit       m_ri = 1'b0;
  bit [7:0] m_byte = 8'h00;
  bit       m_b9 = 1'b0;

  always #10 clk = ~clk;

  mpa_uart_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .os_tick(os_tick),
    .rx_en(rx_en), .mp_mode(mp_mode), .node_addr(node_addr),
    .node_mask(node_mask), .ri_clr(ri_clr), .rx_byte(rx_byte),
    .rx_bit9(rx_bit9), .ri_flag(ri_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench view of the acceptance rule, written position by position
  function automatic bit want(input bit [7:0] d, input bit b9, input bit stop);
    bit own, all;
    if (!rx_en || !stop || m_ri) return 1'b0;
    if (!mp_mode) return 1'b1;
    if (!b9) return 1'b0;
    own = 1'b1;
    all = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (node_mask[i] && (d[i] != node_addr[i])) own = 1'b0;
      if (node_mask[i] && !d[i]) all = 1'b0;
    end
    return own | all;
  endfunction

  // one oversampling period: four clocks, line set first, tick in the third
  task automatic slot(input logic v);
    @(negedge clk) rx_in = v;
    repeat (2) @(negedge clk);
    os_tick = 1'b1;
    @(negedge clk) os_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b1);
  endtask

  // bits: 0 start, 1..8 data LSB first, 9 ninth, 10 stop
  task automatic send(input bit [7:0] d, input bit b9, input bit stop,
                      input int flip_bit, input int flip_slot, input bit chk_mid);
    logic v;
    bit   ri_before;
    ri_before = m_ri;
    for (int b = 0; b < 11; b++) begin
      if (b == 0)      v = 1'b0;
      else if (b < 9)  v = d[b-1];
      else if (b == 9) v = b9;
      else             v = stop;
      for (int s = 0; s < 16; s++) begin
        slot((b == flip_bit && s == flip_slot) ? ~v : v);
        if (chk_mid && b == 10 && s == 4)
          check(ri_flag == ri_before, "R8 early", ri_flag, ri_before);
        if (chk_mid && b == 10 && s == 12)
          check(ri_flag == 1'b1, "R8 by stop end", ri_flag, 1);
      end
    end
    idle(4);
  endtask

  task automatic frame(input bit [7:0] d, input bit b9, input bit stop,
                       input int flip_bit, input int flip_slot, input bit chk_mid,
                       input string req);
    bit acc;
    acc = want(d, b9, stop);
    send(d, b9, stop, flip_bit, flip_slot, chk_mid);
    if (acc) begin
      m_ri = 1'b1;
      m_byte = d;
      m_b9 = b9;
    end
    check(ri_flag == m_ri, req, ri_flag, m_ri);
    check(rx_byte == m_byte, req, rx_byte, m_byte);
    check(rx_bit9 == m_b9, req, rx_bit9, m_b9);
  endtask

  task automatic clear_ri(input string req);
    @(negedge clk) ri_clr = 1'b1;
    @(negedge clk) ri_clr = 1'b0;
    m_ri = 1'b0;
    @(negedge clk);
    check(ri_flag == 1'b0, req, ri_flag, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13
    check(ri_flag == 1'b0, "R13 flag", ri_flag, 0);
    check(rx_byte == 8'h00, "R13 byte", rx_byte, 0);
    check(rx_bit9 == 1'b0, "R13 b9", rx_bit9, 0);
    idle(3);

    // R2 and R12: plain reception, both ninth-bit values
    frame(8'hA5, 1'b0, 1'b1, -1, 0, 1'b0, "R2 b9=0 R12");
    clear_ri("R7 clear");
    frame(8'h3C, 1'b1, 1'b1, -1, 0, 1'b1, "R2 b9=1 R8");
    // R6: buffer full, next frame dropped
    frame(8'h81, 1'b0, 1'b1, -1, 0, 1'b0, "R6 full drop");
    clear_ri("R7 clear");

    // R1: disabled
    rx_en = 1'b0;
    frame(8'h55, 1'b1, 1'b1, -1, 0, 1'b0, "R1 disabled");
    rx_en = 1'b1;
    idle(2);

    // R4 / R3 / R5 with one shared address, mask 1111_1101
    mp_mode = 1'b1;
    node_addr = 8'hC0;
    node_mask = 8'hFD;
    frame(8'hC0, 1'b1, 1'b1, -1, 0, 1'b0, "R4 exact");
    clear_ri("R7 clear");
    frame(8'hC2, 1'b1, 1'b1, -1, 0, 1'b0, "R4 dontcare bit1");
    clear_ri("R7 clear");
    frame(8'hC1, 1'b1, 1'b1, -1, 0, 1'b0, "R4 reject bit0");
    frame(8'hC0, 1'b0, 1'b1, -1, 0, 1'b0, "R3 b9 low");
    frame(8'hFD, 1'b1, 1'b1, -1, 0, 1'b0, "R5 broadcast");
    clear_ri("R7 clear");
    // second node, mask 1111_1110 takes C1
    node_mask = 8'hFE;
    frame(8'hC1, 1'b1, 1'b1, -1, 0, 1'b0, "R4 other mask");
    clear_ri("R7 clear");

    // R9: one flipped mid-bit sample in data bit 3
    mp_mode = 1'b0;
    frame(8'h5A, 1'b0, 1'b1, 4, 7, 1'b0, "R9 vote");
    clear_ri("R7 clear");

    // R10: start too short
    for (int s = 0; s < 16; s++) slot(s < 7 ? 1'b0 : 1'b1);
    idle(4);
    check(ri_flag == m_ri, "R10 false start", ri_flag, m_ri);
    check(rx_byte == m_byte, "R10 false start", rx_byte, m_byte);
    frame(8'h96, 1'b1, 1'b1, -1, 0, 1'b0, "R10 after glitch");
    clear_ri("R7 clear");

    // R11: bad stop bit
    frame(8'h0F, 1'b1, 1'b0, -1, 0, 1'b0, "R11 bad stop");

    // random mix
    for (int k = 0; k < 50; k++) begin
      bit [7:0] d;
      bit       b9;
      mp_mode   = ($urandom % 3) != 0;
      node_addr = 8'($urandom);
      node_mask = 8'($urandom);
      d  = 8'($urandom);
      if (($urandom % 3) == 0) d = (node_addr & node_mask) | (d & ~node_mask);
      b9 = ($urandom % 4) != 0;
      if (($urandom % 4) != 0 && m_ri) clear_ri("R7 rnd clear");
      frame(d, b9, 1'b1, -1, 0, 1'b0, "R4 R5 R6 random");
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule